// File: doc/BRIEF.md
# Rijndael 256-bit Block Encryption Engine

This block encrypts one 256-bit block under a 256-bit key with the Rijndael cipher configured for eight-column blocks and eight-word keys. A requester offers a plaintext and a key with a valid/ready start handshake. The engine copies both into its own registers when it accepts them. It then runs fourteen rounds, one round per clock cycle, and derives each round key from the previous one as it goes. When the last round is done it raises a one-cycle done pulse, and the ciphertext sits on its output. The ciphertext output keeps that value until a later start is accepted and finishes.

Control is a three-state machine. In IDLE the engine is ready. IDLE moves to ROUND when a start is accepted. ROUND loops on itself while rounds remain and moves to FINISH once round fourteen has been applied. FINISH asserts done for one cycle and always returns to IDLE. Every substitution byte is produced by combinational logic that computes the field inverse and then the affine map. No lookup table is stored.

Byte i of a 256-bit bus occupies bits [8i+7:8i]. Byte i of the plaintext lands in column i/4, row i%4 of the state. Byte i of the key is byte i%4 of key word i/4.

Top module: `rj256_enc`

## Requirements
- R1: While reset is held and right after it is released, start_ready_o is 1, done_o is 0 and cipher_o is all zeros.
- R2: start_ready_o is 1 only in IDLE. A start is accepted on a rising edge where start_valid_o and start_ready_o are both 1, and start_ready_o is 0 from the next cycle until FINISH has passed.
- R3: done_o is high for exactly one cycle. It rises after the 14th rising edge that follows the accepting edge (rounds on edges 1 to 14), and start_ready_o returns to 1 one cycle later.
- R4: cipher_o equals the Rijndael encryption of the accepted plaintext under the accepted key. The cipher uses an 8-column state, 14 rounds, and an initial AddRoundKey. Rounds 1 to 13 apply SubBytes, ShiftRows, MixColumns and AddRoundKey. Round 14 omits MixColumns.
- R5: The byte order is: byte i of plain_i, key_i and cipher_o is bits [8i+7:8i]. It maps to state column i/4, row i%4, and to key word i/4, byte i%4.
- R6: cipher_o changes only on the edge that completes round 14. At all other times it holds its value, including across idle stretches and changing inputs.
- R7: start_valid_i asserted while the engine is busy is ignored. The running encryption's result and timing are unchanged.
- R8: Changing plain_i or key_i after acceptance has no effect on the result.
- R9: ShiftRows rotates rows 0, 1, 2 and 3 left by 0, 1, 3 and 4 columns, with wraparound over eight columns.
- R10: The key update rotates and substitutes the last key word, then XORs the round constant into its byte 0. The round constant starts at 0x01 and is doubled in GF(2^8) with 0x1B reduction for each later round. The words then chain by XOR. Word 4 uses the substituted updated word 3 without rotation or constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | Start request |
| start_ready_o | output | 1 | Engine idle and able to accept a start |
| plain_i | input | 256 | Plaintext block |
| key_i | input | 256 | Cipher key |
| done_o | output | 1 | One-cycle pulse when ciphertext is ready |
| cipher_o | output | 256 | Ciphertext, held until the next completion |

## Verification
The engine's outputs are due at fixed offsets from the accepting edge:
- start_ready_o falls one cycle after acceptance.
- done_o and the new cipher_o appear after edge 14.
- done_o falls and start_ready_o returns after edge 15.

The bench drives inputs and samples outputs on falling edges. It counts falling edges from the acceptance and requires done_o first on count 14. It compares cipher_o at that point with its own encryption model. At count 15 it checks that done_o has dropped and start_ready_o is back. The checker module counts cycles from acceptance and requires that done_o coincides with count 15.

// File: rtl/rj_pkg.sv
package rj_pkg;
    localparam int BYTE_W  = 8;
    localparam int ROWS    = 4;
    localparam int NB      = 8;
    localparam int NK      = 8;
    localparam int NR      = ((NB > NK) ? NB : NK) + 6;
    localparam int WORD_W  = ROWS * BYTE_W;
    localparam int BLK_W   = NB * WORD_W;
    localparam int KEY_W   = NK * WORD_W;
    localparam int RND_W   = $clog2(NR + 1);
    localparam int SH_R1   = 1;
    localparam int SH_R2   = 3;
    localparam int SH_R3   = 4;
    localparam logic [7:0] RED_POLY = 8'h1B;
    localparam logic [7:0] AFF_C    = 8'h63;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROUND  = 2'd1,
        ST_FINISH = 2'd2
    } rj_state_e;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? RED_POLY : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = 8'h00;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = xtime(aa);
        end
        return acc;
    endfunction

    // a^254 is the inverse for nonzero a and 0 for a = 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p3, p7, p15, p31, p63, p127;
        p3   = gf_mul(gf_mul(a, a), a);
        p7   = gf_mul(gf_mul(p3, p3), a);
        p15  = gf_mul(gf_mul(p7, p7), a);
        p31  = gf_mul(gf_mul(p15, p15), a);
        p63  = gf_mul(gf_mul(p31, p31), a);
        p127 = gf_mul(gf_mul(p63, p63), a);
        return gf_mul(p127, p127);
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        return 8'((x << n) | (x >> (8 - n)));
    endfunction

    function automatic logic [7:0] sub_byte(input logic [7:0] x);
        logic [7:0] v;
        v = gf_inv(x);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ AFF_C;
    endfunction
endpackage

// File: rtl/rj_sbox.sv
module rj_sbox
    import rj_pkg::*;
(
    input  logic [BYTE_W-1:0] in_i,
    output logic [BYTE_W-1:0] out_o
);
    assign out_o = sub_byte(in_i);
endmodule

// File: rtl/rj_keystep.sv
module rj_keystep
    import rj_pkg::*;
(
    input  logic [KEY_W-1:0]  key_i,
    input  logic [BYTE_W-1:0] rcon_i,
    output logic [KEY_W-1:0]  key_o
);
    localparam int MID = NK / 2;

    logic [WORD_W-1:0] nw [NK];
    logic [WORD_W-1:0] rot_last;
    logic [WORD_W-1:0] sub_last;
    logic [WORD_W-1:0] sub_mid;
    logic [WORD_W-1:0] head;

    // last word rotated by one byte: new byte b takes old byte b+1
    assign rot_last = {key_i[(NK-1)*WORD_W +: BYTE_W],
                       key_i[NK*WORD_W-1 -: (WORD_W-BYTE_W)]};

    for (genvar b = 0; b < ROWS; b++) begin : g_sb
        rj_sbox u_sb_last (.in_i(rot_last[b*BYTE_W +: BYTE_W]), .out_o(sub_last[b*BYTE_W +: BYTE_W]));
        rj_sbox u_sb_mid  (.in_i(nw[MID-1][b*BYTE_W +: BYTE_W]), .out_o(sub_mid[b*BYTE_W +: BYTE_W]));
    end

    assign head = sub_last ^ {{(WORD_W-BYTE_W){1'b0}}, rcon_i};

    for (genvar j = 0; j < NK; j++) begin : g_word
        if (j == 0) begin : g_first
            assign nw[j] = key_i[j*WORD_W +: WORD_W] ^ head;
        end else if (j == MID) begin : g_mid
            assign nw[j] = key_i[j*WORD_W +: WORD_W] ^ sub_mid;
        end else begin : g_chain
            assign nw[j] = key_i[j*WORD_W +: WORD_W] ^ nw[j-1];
        end
        assign key_o[j*WORD_W +: WORD_W] = nw[j];
    end
endmodule

// File: rtl/rj_round.sv
module rj_round
    import rj_pkg::*;
(
    input  logic [BLK_W-1:0] blk_i,
    input  logic [BLK_W-1:0] rkey_i,
    input  logic             last_i,
    output logic [BLK_W-1:0] blk_o
);
    logic [BLK_W-1:0] subbed;
    logic [BLK_W-1:0] shifted;
    logic [BLK_W-1:0] mixed;

    for (genvar c = 0; c < NB; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int SH  = (r == 0) ? 0 : (r == 1) ? SH_R1 : (r == 2) ? SH_R2 : SH_R3;
            localparam int SRC = ((c + SH) % NB) * ROWS + r;
            localparam int DST = c * ROWS + r;
            rj_sbox u_sb (.in_i(blk_i[DST*BYTE_W +: BYTE_W]), .out_o(subbed[DST*BYTE_W +: BYTE_W]));
            assign shifted[DST*BYTE_W +: BYTE_W] = subbed[SRC*BYTE_W +: BYTE_W];
        end

        // column mix: b_r = a_r ^ sum ^ xtime(a_r ^ a_{r+1})
        logic [BYTE_W-1:0] a0, a1, a2, a3, sum;
        assign a0  = shifted[(c*ROWS+0)*BYTE_W +: BYTE_W];
        assign a1  = shifted[(c*ROWS+1)*BYTE_W +: BYTE_W];
        assign a2  = shifted[(c*ROWS+2)*BYTE_W +: BYTE_W];
        assign a3  = shifted[(c*ROWS+3)*BYTE_W +: BYTE_W];
        assign sum = a0 ^ a1 ^ a2 ^ a3;
        assign mixed[(c*ROWS+0)*BYTE_W +: BYTE_W] = a0 ^ sum ^ xtime(a0 ^ a1);
        assign mixed[(c*ROWS+1)*BYTE_W +: BYTE_W] = a1 ^ sum ^ xtime(a1 ^ a2);
        assign mixed[(c*ROWS+2)*BYTE_W +: BYTE_W] = a2 ^ sum ^ xtime(a2 ^ a3);
        assign mixed[(c*ROWS+3)*BYTE_W +: BYTE_W] = a3 ^ sum ^ xtime(a3 ^ a0);
    end

    assign blk_o = (last_i ? shifted : mixed) ^ rkey_i;
endmodule

// File: rtl/rj256_enc.sv
module rj256_enc
    import rj_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_valid_i,
    output logic             start_ready_o,
    input  logic [BLK_W-1:0] plain_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             done_o,
    output logic [BLK_W-1:0] cipher_o
);
    rj_state_e         st_q, st_d;
    logic [BLK_W-1:0]  blk_q;
    logic [KEY_W-1:0]  rkey_q;
    logic [BYTE_W-1:0] rcon_q;
    logic [RND_W-1:0]  rnd_q;
    logic [BLK_W-1:0]  cipher_q;
    logic [BLK_W-1:0]  blk_next;
    logic [KEY_W-1:0]  rkey_next;
    logic              accept;
    logic              last_rnd;

    assign accept   = start_valid_i && (st_q == ST_IDLE);
    assign last_rnd = (rnd_q == RND_W'(NR));

    rj_keystep u_key (
        .key_i  (rkey_q),
        .rcon_i (rcon_q),
        .key_o  (rkey_next)
    );

    rj_round u_rnd (
        .blk_i  (blk_q),
        .rkey_i (rkey_next),
        .last_i (last_rnd),
        .blk_o  (blk_next)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (accept)   st_d = ST_ROUND;
            ST_ROUND:  if (last_rnd) st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    always_comb begin
        start_ready_o = 1'b0;
        done_o        = 1'b0;
        unique case (st_q)
            ST_IDLE:   start_ready_o = 1'b1;
            ST_ROUND:  ;
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            blk_q    <= '0;
            rkey_q   <= '0;
            rcon_q   <= '0;
            rnd_q    <= '0;
            cipher_q <= '0;
        end else if (accept) begin
            blk_q  <= plain_i ^ key_i;
            rkey_q <= key_i;
            rcon_q <= 8'h01;
            rnd_q  <= RND_W'(1);
        end else if (st_q == ST_ROUND) begin
            blk_q  <= blk_next;
            rkey_q <= rkey_next;
            rcon_q <= xtime(rcon_q);
            rnd_q  <= rnd_q + RND_W'(1);
            if (last_rnd) cipher_q <= blk_next;
        end
    end

    assign cipher_o = cipher_q;
endmodule

// File: rtl/rj256_enc_chk.sv
module rj256_enc_chk
    import rj_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_valid_i,
    input logic             start_ready_o,
    input logic             done_o,
    input logic [BLK_W-1:0] cipher_o
);
    localparam int LAT   = NR + 1;
    localparam int CYC_W = $clog2(LAT + 1) + 1;

    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            cyc_q <= '0;
        else if (done_o)                        cyc_q <= '0;
        else if (start_valid_i && start_ready_o) cyc_q <= CYC_W'(1);
        else if (cyc_q != '0)                   cyc_q <= cyc_q + CYC_W'(1);
    end

    a_r3_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r3_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (cyc_q == CYC_W'(LAT)));

    a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_valid_i && start_ready_o) |=> !start_ready_o);

    a_r7_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q != '0) |-> !start_ready_o);

    a_r6_cipher_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(cipher_o));
endmodule

bind rj256_enc rj256_enc_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_valid_i (start_valid_i),
    .start_ready_o (start_ready_o),
    .done_o        (done_o),
    .cipher_o      (cipher_o)
);

// File: tb/rj256_enc_bench.sv
module rj256_enc_bench;
    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         start_valid_i = 1'b0;
    logic         start_ready_o;
    logic [255:0] plain_i = '0;
    logic [255:0] key_i = '0;
    logic         done_o;
    logic [255:0] cipher_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [7:0] sb [256];

    rj256_enc u_rj256_enc (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_valid_i (start_valid_i),
        .start_ready_o (start_ready_o),
        .plain_i       (plain_i),
        .key_i         (key_i),
        .done_o        (done_o),
        .cipher_o      (cipher_o)
    );

    always #2 clk_i = ~clk_i;

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m2(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    endfunction

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = m2(x);
        end
        return r;
    endfunction

    function automatic int row_off(input int row);
        case (row)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    // independent model: R4 R5 R9 R10
    function automatic logic [255:0] ref_enc(input logic [255:0] pt, input logic [255:0] key);
        logic [7:0] w [120][4];
        logic [7:0] t [4];
        logic [7:0] tmp;
        logic [7:0] rc;
        logic [7:0] s [32];
        logic [7:0] u [32];
        logic [7:0] a0, a1, a2, a3;
        logic [255:0] out;
        for (int j = 0; j < 8; j++)
            for (int b = 0; b < 4; b++) w[j][b] = key[8*(4*j+b) +: 8];
        rc = 8'h01;
        for (int i = 8; i < 120; i++) begin
            for (int b = 0; b < 4; b++) t[b] = w[i-1][b];
            if (i % 8 == 0) begin
                tmp = t[0]; t[0] = t[1]; t[1] = t[2]; t[2] = t[3]; t[3] = tmp;
                for (int b = 0; b < 4; b++) t[b] = sb[t[b]];
                t[0] ^= rc;
                rc = gm(rc, 8'h02);
            end else if (i % 8 == 4) begin
                for (int b = 0; b < 4; b++) t[b] = sb[t[b]];
            end
            for (int b = 0; b < 4; b++) w[i][b] = w[i-8][b] ^ t[b];
        end
        for (int k = 0; k < 32; k++) s[k] = pt[8*k +: 8] ^ w[k/4][k%4];
        for (int r = 1; r <= 14; r++) begin
            for (int k = 0; k < 32; k++) u[k] = sb[s[k]];
            for (int c = 0; c < 8; c++)
                for (int row = 0; row < 4; row++)
                    s[c*4+row] = u[((c + row_off(row)) % 8)*4 + row];
            if (r < 14) begin
                for (int c = 0; c < 8; c++) begin
                    a0 = s[c*4]; a1 = s[c*4+1]; a2 = s[c*4+2]; a3 = s[c*4+3];
                    s[c*4]   = gm(a0,2) ^ gm(a1,3) ^ a2 ^ a3;
                    s[c*4+1] = a0 ^ gm(a1,2) ^ gm(a2,3) ^ a3;
                    s[c*4+2] = a0 ^ a1 ^ gm(a2,2) ^ gm(a3,3);
                    s[c*4+3] = gm(a0,3) ^ a1 ^ a2 ^ gm(a3,2);
                end
            end
            for (int k = 0; k < 32; k++) s[k] ^= w[8*r + k/4][k%4];
        end
        for (int k = 0; k < 32; k++) out[8*k +: 8] = s[k];
        return out;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic run_enc(input logic [255:0] pt, input logic [255:0] key,
                           input bit poke, input bit scramble, input string tag);
        logic [255:0] exp;
        logic [255:0] held;
        int k;
        exp = ref_enc(pt, key);
        @(negedge clk_i);
        chk({"R2 ready before start ", tag}, 256'(start_ready_o), 256'(1));
        plain_i = pt; key_i = key; start_valid_i = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        start_valid_i = 1'b0;
        chk({"R2 busy after accept ", tag}, 256'(start_ready_o), 256'(0));
        if (scramble) begin
            plain_i = ~pt; key_i = rnd256();
        end
        if (poke) begin
            start_valid_i = 1'b1; plain_i = rnd256(); key_i = rnd256();
        end
        k = 0;
        while (!done_o && k < 40) begin
            @(negedge clk_i);
            k++;
            if (poke && !done_o && start_ready_o) begin
                n_chk++; n_fail++;
                $display("FAIL R7 ready while busy act=1 exp=0");
            end
        end
        start_valid_i = 1'b0;
        chk({"R3 done latency ", tag}, 256'(k), 256'(14));
        chk({"R4 ciphertext ", tag}, cipher_o, exp);
        if (scramble) chk({"R8 inputs changed after accept ", tag}, cipher_o, exp);
        if (poke)     chk({"R7 busy start ignored ", tag}, cipher_o, exp);
        held = cipher_o;
        @(negedge clk_i);
        chk({"R3 done one cycle ", tag}, 256'(done_o), 256'(0));
        chk({"R3 ready back ", tag}, 256'(start_ready_o), 256'(1));
        plain_i = rnd256(); key_i = rnd256();
        repeat (3) @(negedge clk_i);
        chk({"R6 cipher held ", tag}, cipher_o, held);
    endtask

    initial begin
        logic [7:0] inv;
        logic [7:0] v;
        logic [255:0] ramp;
        void'($urandom(32'd20240611));
        for (int x = 0; x < 256; x++) begin
            inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                v[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
            sb[x] = v;
        end

        #1;
        chk("R1 ready in reset", 256'(start_ready_o), 256'(1));
        chk("R1 done in reset", 256'(done_o), 256'(0));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1 ready after reset", 256'(start_ready_o), 256'(1));
        chk("R1 done after reset", 256'(done_o), 256'(0));
        chk("R1 cipher after reset", cipher_o, '0);

        run_enc('0, '0, 1'b0, 1'b0, "zero R9 R10");
        run_enc('1, '1, 1'b0, 1'b0, "ones R9 R10");
        for (int i = 0; i < 32; i++) ramp[8*i +: 8] = 8'(i);
        run_enc(ramp, '0, 1'b0, 1'b0, "R5 byte ramp plain");
        run_enc('0, ramp, 1'b0, 1'b0, "R5 byte ramp key");
        run_enc(256'h80, '0, 1'b0, 1'b0, "R9 single byte");
        run_enc(rnd256(), rnd256(), 1'b1, 1'b0, "R7 poke");
        run_enc(rnd256(), rnd256(), 1'b0, 1'b1, "R8 scramble");
        run_enc(rnd256(), rnd256(), 1'b1, 1'b1, "R7 R8 both");
        for (int n = 0; n < 12; n++)
            run_enc(rnd256(), rnd256(), ($urandom % 3) == 0, ($urandom % 2) == 0, "R4 random");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule